// File: doc/BRIEF.md
# Descriptor-chain SPI transfer sequencer

This block runs a list of SPI transfers that software has laid out in memory as a packed table of fixed-size descriptors. After software writes the table's base address and sets the start bit, the sequencer reads one descriptor word by word over a simple memory read port. It decodes the descriptor and hands one command to the serial bus engine. When the engine reports the command done, the sequencer moves to the next descriptor in the table. It stops after the descriptor that carries the end-of-chain flag.

The command sent to the bus engine carries the fields the engine needs: the operation, the bytes per block and block count, the transmit and receive data modes, the lane mode, whether chip select stays asserted after the command, a clock-only filler flag used to stretch chip-select hold, and the two buffer addresses. The sequencer moves no data itself. It sequences descriptors and reports status through a small register port and one interrupt line. Software can stop a running chain at any time by writing zero to the upper base-address word.

Top module: `spi_desc_seq`

## Requirements
- R1: A descriptor is six 32-bit little-endian words read at consecutive byte addresses base+0, +4, … +20. Word 0 is start-config, word 1 is bus-config, words 2/3 are the transmit address (low, high) and words 4/5 are the receive address (low, high). The next descriptor starts 24 bytes later. A read address stays steady until the memory answers with `mem_rvalid`.
- R2: Start-config fields go to the command unchanged: block count from bits [19:0], bytes per block from [22:20], operation from [25:24] (0 write command, 1 read status, 2 write, 3 read), receive data mode from [27:26] and transmit data mode from [29:28] (0 none, 1 register, 2 contiguous memory, 3 scatter list). Bit 30 marks the end of the chain. The fields hold steady while `cmd_valid` waits.
- R3: Bus-config fields go to the command: lane mode from bits [21:20], the clock-only filler flag from bit 25 and the keep-chip-select flag from bit 29. All other bus-config bits are not decoded.
- R4: Register index 0 holds the low 32 bits of the base address and index 1 holds the upper 31 bits in [30:0]. A write to index 1 with bit 31 set while idle starts the chain at that base. While the chain runs, writes to index 0 and nonzero writes to index 1 are ignored.
- R5: The block issues exactly one command per descriptor. `cmd_valid` stays high until `cmd_done` is seen. No memory read is requested while a command is outstanding.
- R6: After `cmd_done` for the end-of-chain descriptor, the block returns to idle and fetches nothing more. It sets chain-done status (bit 11 of register index 2) only if enable bit 11 of register index 3 is set at that moment.
- R7: A read answered with `mem_rerr` sets descriptor-error status (bit 8 of index 2), returns the block to idle, and issues no further command.
- R8: Writing zero to index 1 while running aborts the chain. `cmd_valid` and `mem_req` are low from the next cycle, and no chain-done status is set.
- R9: Status bits clear when 1 is written to them at index 2. If hardware sets a bit in the same cycle that software clears it, the bit ends up set.
- R10: `irq` is high exactly when some status bit and its enable bit (index 3, bits 8 and 11) are both set.
- R11: After reset every register reads zero, the block is idle, and `irq`, `mem_req` and `cmd_valid` are low.
- R12: Bit 31 of index 1 reads 1 from the cycle after a start until the chain ends, aborts or fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 64 | Descriptor word byte address |
| mem_rvalid | input | 1 | Read answer valid |
| mem_rerr | input | 1 | Read answer carries an error |
| mem_rdata | input | 32 | Read answer data |
| cmd_valid | output | 1 | Command to bus engine pending |
| cmd_done | input | 1 | Bus engine finished the command |
| cmd_op | output | 2 | Operation code |
| cmd_blk_size | output | 3 | Bytes per block |
| cmd_blk_cnt | output | 20 | Block count |
| cmd_tx_mode | output | 2 | Transmit data mode |
| cmd_rx_mode | output | 2 | Receive data mode |
| cmd_lane | output | 2 | Lane mode |
| cmd_keep_cs | output | 1 | Keep chip select asserted afterwards |
| cmd_null_clk | output | 1 | Clock-only filler command |
| cmd_tx_addr | output | 64 | Transmit buffer address |
| cmd_rx_addr | output | 64 | Receive buffer address |

## Verification
Two events can land in the same cycle: the hardware setting chain-done when the last command completes, and a software write-one-to-clear of the status register. The bench's bus-engine model raises `cmd_done` for the end-of-chain command and drives a clear of bit 11 onto the register port on the same edge. The status is then read back, and the bit must still be set. Chain sweeps of one to four descriptors, with and without memory stalls and with the interrupt enable on and off, surround this case. Every command field is compared against values computed from the descriptor index.

// File: rtl/sds_pkg.sv
package sds_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 6;
  localparam int BCNT_W     = 20;

  localparam int START_BIT  = 31;
  localparam int STAT_ERR   = 8;
  localparam int STAT_DONE  = 11;

  localparam int SC_CNT_LSB  = 0;
  localparam int SC_SIZE_LSB = 20;
  localparam int SC_OP_LSB   = 24;
  localparam int SC_RXM_LSB  = 26;
  localparam int SC_TXM_LSB  = 28;
  localparam int SC_EOC_BIT  = 30;

  localparam int BC_LANE_LSB = 20;
  localparam int BC_NULL_BIT = 25;
  localparam int BC_KEEP_BIT = 29;

  localparam logic [1:0] RA_LO   = 2'd0;
  localparam logic [1:0] RA_HI   = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_EN   = 2'd3;

  typedef enum logic [1:0] {OP_WCMD, OP_RSTS, OP_WRITE, OP_READ} op_e;
  typedef enum logic [1:0] {DM_NONE, DM_REG, DM_MEM, DM_LIST} dmode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_ISSUE} wstate_e;

  typedef struct packed {
    op_e               op;
    logic [2:0]        blk_size;
    logic [BCNT_W-1:0] blk_cnt;
    dmode_e            tx_mode;
    dmode_e            rx_mode;
    logic [1:0]        lane;
    logic              keep_cs;
    logic              null_clk;
    logic [63:0]       tx_addr;
    logic [63:0]       rx_addr;
  } cmd_t;
endpackage

// File: rtl/sds_regs.sv
module sds_regs
  import sds_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic              busy,
  input  logic              hw_done,
  input  logic              hw_err,
  output logic              start,
  output logic              abort,
  output logic [ADDR_W-1:0] start_base,
  output logic [1:0]        stat_bits,
  output logic [1:0]        en_bits
);
  localparam int HI_W = WORD_W - 1;

  logic [WORD_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [1:0]        stat_q, stat_d, en_q, clr, set;
  logic              hit_hi, lo_en, hi_en, en_en;

  always_comb begin
    hit_hi = we && (addr == RA_HI);
    start  = hit_hi && wdata[START_BIT] && !busy;
    abort  = hit_hi && (wdata == '0) && busy;
    lo_en  = we && (addr == RA_LO) && !busy;
    hi_en  = hit_hi && !busy;
    en_en  = we && (addr == RA_EN);
    clr    = (we && (addr == RA_STAT)) ? {wdata[STAT_DONE], wdata[STAT_ERR]} : 2'b00;
    set    = {hw_done & en_q[1], hw_err};
    stat_d = (stat_q & ~clr) | set;
    start_base = ADDR_W'({1'b0, wdata[HI_W-1:0], lo_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      if (lo_en) lo_q <= wdata;
      if (hi_en) hi_q <= wdata[HI_W-1:0];
      if (en_en) en_q <= {wdata[STAT_DONE], wdata[STAT_ERR]};
      stat_q <= stat_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_LO:   rdata = lo_q;
      RA_HI:   rdata = {busy, hi_q};
      RA_STAT: begin
        rdata[STAT_DONE] = stat_q[1];
        rdata[STAT_ERR]  = stat_q[0];
      end
      default: begin
        rdata[STAT_DONE] = en_q[1];
        rdata[STAT_ERR]  = en_q[0];
      end
    endcase
  end

  assign stat_bits = stat_q;
  assign en_bits   = en_q;
endmodule

// File: rtl/sds_unpack.sv
module sds_unpack
  import sds_pkg::*;
(
  input  logic [DESC_WORDS*WORD_W-1:0] desc_words,
  output cmd_t                         cmd
);
  logic [WORD_W-1:0] w [DESC_WORDS];

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_split
    assign w[g] = desc_words[g*WORD_W +: WORD_W];
  end

  always_comb begin
    cmd.blk_cnt  = w[0][SC_CNT_LSB +: BCNT_W];
    cmd.blk_size = w[0][SC_SIZE_LSB +: 3];
    cmd.op       = op_e'(w[0][SC_OP_LSB +: 2]);
    cmd.rx_mode  = dmode_e'(w[0][SC_RXM_LSB +: 2]);
    cmd.tx_mode  = dmode_e'(w[0][SC_TXM_LSB +: 2]);
    cmd.lane     = w[1][BC_LANE_LSB +: 2];
    cmd.null_clk = w[1][BC_NULL_BIT];
    cmd.keep_cs  = w[1][BC_KEEP_BIT];
    cmd.tx_addr  = {w[3], w[2]};
    cmd.rx_addr  = {w[5], w[4]};
  end
endmodule

// File: rtl/sds_walker.sv
module sds_walker
  import sds_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         abort,
  input  logic [ADDR_W-1:0]            start_base,
  output logic                         mem_req,
  output logic [ADDR_W-1:0]            mem_addr,
  input  logic                         mem_rvalid,
  input  logic                         mem_rerr,
  input  logic [WORD_W-1:0]            mem_rdata,
  output logic                         cmd_valid,
  input  logic                         cmd_done,
  output logic [DESC_WORDS*WORD_W-1:0] desc_words,
  output logic                         busy,
  output logic                         chain_done,
  output logic                         desc_err
);
  localparam int              IDX_W   = $clog2(DESC_WORDS);
  localparam int              BSHIFT  = $clog2(WORD_W / 8);
  localparam logic [IDX_W-1:0] LAST   = IDX_W'(DESC_WORDS - 1);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(DESC_WORDS * (WORD_W / 8));

  wstate_e           state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              word_we;
  logic [WORD_W-1:0] words_q [DESC_WORDS];

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    base_d     = base_q;
    word_we    = 1'b0;
    chain_done = 1'b0;
    desc_err   = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_FETCH;
        idx_d   = '0;
        base_d  = start_base;
      end
      ST_FETCH: if (mem_rvalid) begin
        if (mem_rerr) begin
          desc_err = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          word_we = 1'b1;
          if (idx_q == LAST) begin
            idx_d   = '0;
            state_d = ST_ISSUE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_ISSUE: if (cmd_done) begin
        if (words_q[0][SC_EOC_BIT]) begin
          chain_done = 1'b1;
          state_d    = ST_IDLE;
        end else begin
          base_d  = base_q + STRIDE;
          state_d = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort) begin
      state_d    = ST_IDLE;
      word_we    = 1'b0;
      chain_done = 1'b0;
      desc_err   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      base_q  <= base_d;
    end
  end

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words_q[g] <= '0;
      end else if (word_we && (idx_q == IDX_W'(g))) begin
        words_q[g] <= mem_rdata;
      end
    end
    assign desc_words[g*WORD_W +: WORD_W] = words_q[g];
  end

  assign mem_req   = (state_q == ST_FETCH);
  assign mem_addr  = base_q + (ADDR_W'(idx_q) << BSHIFT);
  assign cmd_valid = (state_q == ST_ISSUE);
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/spi_desc_seq.sv
module spi_desc_seq
  import sds_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic        mem_rerr,
  input  logic [31:0] mem_rdata,
  output logic        cmd_valid,
  input  logic        cmd_done,
  output logic [1:0]  cmd_op,
  output logic [2:0]  cmd_blk_size,
  output logic [19:0] cmd_blk_cnt,
  output logic [1:0]  cmd_tx_mode,
  output logic [1:0]  cmd_rx_mode,
  output logic [1:0]  cmd_lane,
  output logic        cmd_keep_cs,
  output logic        cmd_null_clk,
  output logic [63:0] cmd_tx_addr,
  output logic [63:0] cmd_rx_addr
);
  localparam int ADDR_W = 64;

  logic [1:0]                   rs_q;
  logic                         rst_sync_n;
  logic                         busy, start_req, abort_req, hw_done, hw_err;
  logic [ADDR_W-1:0]            start_base;
  logic [1:0]                   stat_bits, en_bits;
  logic [DESC_WORDS*WORD_W-1:0] desc_words;
  cmd_t                         cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  sds_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy),
    .hw_done(hw_done), .hw_err(hw_err), .start(start_req),
    .abort(abort_req), .start_base(start_base),
    .stat_bits(stat_bits), .en_bits(en_bits)
  );

  sds_walker #(.ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_sync_n), .start(start_req), .abort(abort_req),
    .start_base(start_base), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rerr(mem_rerr), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_done(cmd_done), .desc_words(desc_words),
    .busy(busy), .chain_done(hw_done), .desc_err(hw_err)
  );

  sds_unpack u_unpack (.desc_words(desc_words), .cmd(cmd));

  assign irq          = |(stat_bits & en_bits);
  assign cmd_op       = cmd.op;
  assign cmd_blk_size = cmd.blk_size;
  assign cmd_blk_cnt  = cmd.blk_cnt;
  assign cmd_tx_mode  = cmd.tx_mode;
  assign cmd_rx_mode  = cmd.rx_mode;
  assign cmd_lane     = cmd.lane;
  assign cmd_keep_cs  = cmd.keep_cs;
  assign cmd_null_clk = cmd.null_clk;
  assign cmd_tx_addr  = cmd.tx_addr;
  assign cmd_rx_addr  = cmd.rx_addr;
endmodule

// File: rtl/sds_checker.sv
module sds_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic [63:0] mem_addr,
  input logic        mem_rvalid,
  input logic        mem_rerr,
  input logic        cmd_valid,
  input logic        cmd_done,
  input logic [19:0] cmd_blk_cnt,
  input logic [63:0] cmd_tx_addr,
  input logic [1:0]  stat_bits,
  input logic        abort_req
);
  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && cmd_valid));

  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done && !abort_req |=> cmd_valid);

  // R2
  cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done && !abort_req |=> $stable(cmd_blk_cnt) && $stable(cmd_tx_addr));

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid && !abort_req |=> mem_req && $stable(mem_addr));

  // R7
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rvalid && mem_rerr && !abort_req |=> !mem_req && !cmd_valid && stat_bits[0]);

  // R6
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_bits[1]) |-> $past(cmd_done));

  // R8
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !mem_req && !cmd_valid);
endmodule

bind spi_desc_seq sds_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .mem_rerr(mem_rerr), .cmd_valid(cmd_valid),
  .cmd_done(cmd_done), .cmd_blk_cnt(cmd_blk_cnt), .cmd_tx_addr(cmd_tx_addr),
  .stat_bits(stat_bits), .abort_req(abort_req)
);

// File: tb/spi_desc_seq_tb.sv
module spi_desc_seq_tb;
  localparam logic [31:0] BASE_LO = 32'h0000_1000;
  localparam logic [30:0] BASE_HI = 31'h12;
  localparam logic [63:0] BASE    = {1'b0, BASE_HI, BASE_LO};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        tb_we = 1'b0;
  logic [1:0]  tb_addr = 2'd0;
  logic [31:0] tb_wdata = 32'd0;
  logic        eng_clr = 1'b0;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, mem_req, mem_rvalid = 1'b0, mem_rerr = 1'b0;
  logic [63:0] mem_addr;
  logic [31:0] mem_rdata = 32'd0;
  logic        cmd_valid, cmd_done = 1'b0;
  logic [1:0]  cmd_op, cmd_tx_mode, cmd_rx_mode, cmd_lane;
  logic [2:0]  cmd_blk_size;
  logic [19:0] cmd_blk_cnt;
  logic        cmd_keep_cs, cmd_null_clk;
  logic [63:0] cmd_tx_addr, cmd_rx_addr;

  assign reg_we    = tb_we | eng_clr;
  assign reg_addr  = eng_clr ? 2'd2 : tb_addr;
  assign reg_wdata = eng_clr ? 32'h0000_0800 : tb_wdata;

  spi_desc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rerr(mem_rerr), .mem_rdata(mem_rdata), .cmd_valid(cmd_valid),
    .cmd_done(cmd_done), .cmd_op(cmd_op), .cmd_blk_size(cmd_blk_size),
    .cmd_blk_cnt(cmd_blk_cnt), .cmd_tx_mode(cmd_tx_mode),
    .cmd_rx_mode(cmd_rx_mode), .cmd_lane(cmd_lane),
    .cmd_keep_cs(cmd_keep_cs), .cmd_null_clk(cmd_null_clk),
    .cmd_tx_addr(cmd_tx_addr), .cmd_rx_addr(cmd_rx_addr)
  );

  int checks = 0, failures = 0, cyc = 0;
  int stall = 0, lat = 2, err_idx = -1, clr_at_done = 0;
  int ncmd = 0, lat_cnt = 0;
  logic [31:0] mem [64];
  logic [1:0]  lg_op [16], lg_txm [16], lg_rxm [16], lg_lane [16];
  logic [2:0]  lg_size [16];
  logic [19:0] lg_cnt [16];
  logic        lg_keep [16], lg_null [16];
  logic [63:0] lg_tx [16], lg_rx [16];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected descriptor fields, computed from chain length n and index i
  function automatic logic [19:0] e_cnt(int n, int i); return 20'(i*4099 + n*17 + 1); endfunction
  function automatic logic [2:0]  e_size(int n, int i); return 3'(i + n); endfunction
  function automatic logic [1:0]  e_op(int n, int i);   return 2'(i + n + 1); endfunction
  function automatic logic [1:0]  e_rxm(int i);         return 2'(i); endfunction
  function automatic logic [1:0]  e_txm(int i);         return 2'(i + 2); endfunction
  function automatic logic [1:0]  e_lane(int n, int i); return 2'((i + n) % 3); endfunction
  function automatic logic        e_null(int i);        return 1'(i & 1); endfunction
  function automatic logic [63:0] e_tx(int n, int i);   return {16'hA5A5, 16'(n), 32'(i*256 + 16)}; endfunction
  function automatic logic [63:0] e_rx(int n, int i);   return {16'h5A5A, 16'(n), 32'(i*512 + 8)}; endfunction

  task automatic build(int n);
    for (int i = 0; i <= n; i++) begin
      logic eoc = (i == n - 1);
      mem[i*6+0] = {1'b1, eoc, e_txm(i), e_rxm(i), e_op(n, i), 1'b0, e_size(n, i), e_cnt(n, i)};
      mem[i*6+1] = 32'h0000_F0FF | ({30'd0, e_lane(n, i)} << 20) |
                   ({31'd0, e_null(i)} << 25) | ({31'd0, !eoc} << 29) | 32'hC000_0000;
      mem[i*6+2] = e_tx(n, i)[31:0];
      mem[i*6+3] = e_tx(n, i)[63:32];
      mem[i*6+4] = e_rx(n, i)[31:0];
      mem[i*6+5] = e_rx(n, i)[63:32];
    end
  endtask

  // memory and bus-engine models, driven away from the active edge
  always @(negedge clk) begin
    int idx;
    cyc++;
    idx = int'((mem_addr - BASE) >> 2);
    mem_rvalid = mem_req && (stall == 0 || (cyc % 3) == 0);
    mem_rerr   = mem_rvalid && (idx == err_idx);
    mem_rdata  = (idx >= 0 && idx < 64) ? mem[idx] : 32'hDEAD_BEEF;
    eng_clr    = 1'b0;
    cmd_done   = 1'b0;
    if (cmd_valid) begin
      if (lat_cnt == lat) begin
        cmd_done = 1'b1;
        lat_cnt  = 0;
        if (ncmd < 16) begin
          lg_op[ncmd] = cmd_op; lg_size[ncmd] = cmd_blk_size; lg_cnt[ncmd] = cmd_blk_cnt;
          lg_txm[ncmd] = cmd_tx_mode; lg_rxm[ncmd] = cmd_rx_mode; lg_lane[ncmd] = cmd_lane;
          lg_keep[ncmd] = cmd_keep_cs; lg_null[ncmd] = cmd_null_clk;
          lg_tx[ncmd] = cmd_tx_addr; lg_rx[ncmd] = cmd_rx_addr;
        end
        ncmd++;
        if (clr_at_done != 0 && !cmd_keep_cs) eng_clr = 1'b1;
      end else begin
        lat_cnt++;
      end
    end else begin
      lat_cnt = 0;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); #1;
    tb_we = 1'b1; tb_addr = a; tb_wdata = d;
    @(negedge clk); #1;
    tb_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk); #1;
    tb_addr = a; #1;
    v = reg_rdata;
  endtask

  task automatic wait_idle(string req);
    logic [31:0] v;
    for (int k = 0; k < 5000; k++) begin
      rd(2'd1, v);
      if (!v[31]) return;
    end
    check({req, " idle timeout"}, 64'd1, 64'd0);
  endtask

  task automatic start_chain();
    wr(2'd0, BASE_LO);
    wr(2'd1, {1'b1, BASE_HI});
  endtask

  task automatic check_cmds(int n);
    check("R5 command count", 64'(ncmd), 64'(n));
    for (int i = 0; i < n && i < 16; i++) begin
      check("R2 op", 64'(lg_op[i]), 64'(e_op(n, i)));
      check("R2 blk_size", 64'(lg_size[i]), 64'(e_size(n, i)));
      check("R2 blk_cnt", 64'(lg_cnt[i]), 64'(e_cnt(n, i)));
      check("R2 tx_mode", 64'(lg_txm[i]), 64'(e_txm(i)));
      check("R2 rx_mode", 64'(lg_rxm[i]), 64'(e_rxm(i)));
      check("R3 lane", 64'(lg_lane[i]), 64'(e_lane(n, i)));
      check("R3 null_clk", 64'(lg_null[i]), 64'(e_null(i)));
      check("R3 keep_cs", 64'(lg_keep[i]), 64'(i != n - 1));
      check("R1 tx_addr", lg_tx[i], e_tx(n, i));
      check("R1 rx_addr", lg_rx[i], e_rx(n, i));
    end
  endtask

  initial begin
    logic [31:0] v;
    for (int k = 0; k < 64; k++) mem[k] = 32'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R11 reg reset", 64'(v), 64'd0);
    end
    check("R11 irq reset", 64'(irq), 64'd0);
    check("R11 mem_req reset", 64'(mem_req), 64'd0);
    check("R11 cmd_valid reset", 64'(cmd_valid), 64'd0);

    // chain sweep: length, interrupt enable, memory stalls
    for (int n = 1; n <= 4; n++) begin
      for (int en = 0; en < 2; en++) begin
        for (int s = 0; s < 2; s++) begin
          build(n);
          stall = s; lat = 1 + n; ncmd = 0;
          wr(2'd3, en != 0 ? 32'h0000_0900 : 32'd0);
          start_chain();
          rd(2'd1, v);
          check("R12 busy after start", 64'(v[31]), 64'd1);
          wait_idle("R6");
          repeat (3) @(negedge clk);
          check_cmds(n);
          rd(2'd2, v);
          check("R6 chain-done status gated", 64'(v[11]), 64'(en));
          check("R10 irq", 64'(irq), 64'(en));
          wr(2'd2, 32'h0000_0900);
          rd(2'd2, v);
          check("R9 write-one clear", 64'(v), 64'd0);
          check("R10 irq after clear", 64'(irq), 64'd0);
        end
      end
    end
    stall = 0;

    // R7 fetch error on descriptor 1, word 1
    build(3); ncmd = 0; lat = 2; err_idx = 7;
    wr(2'd3, 32'h0000_0100);
    start_chain();
    wait_idle("R7");
    repeat (5) @(negedge clk);
    err_idx = -1;
    check("R7 commands before error", 64'(ncmd), 64'd1);
    rd(2'd2, v);
    check("R7 error status", 64'(v), 64'h100);
    check("R10 irq on error", 64'(irq), 64'd1);
    check("R7 no mem_req after error", 64'(mem_req), 64'd0);
    wr(2'd2, 32'h0000_0100);

    // R8 abort while a command waits
    build(3); ncmd = 0; lat = 40;
    wr(2'd3, 32'h0000_0900);
    start_chain();
    for (int k = 0; k < 200 && !cmd_valid; k++) @(negedge clk);
    wr(2'd1, 32'd0);
    check("R8 cmd_valid dropped", 64'(cmd_valid), 64'd0);
    check("R8 mem_req low", 64'(mem_req), 64'd0);
    repeat (50) @(negedge clk);
    rd(2'd1, v);
    check("R8 idle after abort", 64'(v[31]), 64'd0);
    check("R8 no command completed", 64'(ncmd), 64'd0);
    rd(2'd2, v);
    check("R8 no chain-done", 64'(v), 64'd0);

    // R4 base writes ignored while running
    build(2); ncmd = 0; lat = 12;
    start_chain();
    wr(2'd1, 32'h8000_0055);
    wr(2'd0, 32'h0000_1234);
    wait_idle("R4");
    repeat (3) @(negedge clk);
    check_cmds(2);
    rd(2'd1, v);
    check("R4 high base kept", 64'(v), 64'({1'b0, BASE_HI}));
    rd(2'd0, v);
    check("R4 low base kept", 64'(v), 64'(BASE_LO));
    wr(2'd2, 32'h0000_0900);

    // R9 hardware set and software clear in the same cycle
    build(1); ncmd = 0; lat = 3; clr_at_done = 1;
    wr(2'd3, 32'h0000_0800);
    start_chain();
    wait_idle("R9");
    clr_at_done = 0;
    rd(2'd2, v);
    check("R9 set wins over clear", 64'(v[11]), 64'd1);
    wr(2'd2, 32'h0000_0800);
    rd(2'd2, v);
    check("R9 clear afterwards", 64'(v[11]), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule